// File: doc/BRIEF.md
# Mailbox Command Engine

This block is the device end of a register-mapped mailbox. A host reaches it through a plain single-cycle register bus and finds three things there: a sixteen-dword staging window, a command word and a status word. The host fills the window if needed and then writes a command word with its request bit set. The engine holds that bit high while it works and clears it when the command has finished. The host therefore polls the command word until the bit reads zero, and then reads the status word.

Behind the mailbox sit two equal banks of dword storage. One bank is active and the other is inactive. Block reads copy dwords from the active bank into the window. Block writes copy window dwords into the inactive bank. An update-authenticate command checks a fixed signature dword in the inactive bank; if it matches, the two banks trade roles. A power-cycle command raises a one-cycle restart pulse. Every command stays busy for a parameterised number of cycles before it runs, so host polling takes real time.

The command word is packed as follows. Operation code in bits 31:28, dword count in bits 27:24, dword address in bits 23:2, header flag in bit 1, request in bit 0. The status word carries a response flag in bit 29, the code of the executed operation in bits 7:4 and a result code in bits 3:0.

Top module: `mbox_cmd_engine`

## Requirements
- R1: After reset every register offset reads 0, and bank 0 is the active bank with every storage dword 0.
- R2: Bus offsets: window dword i (i = 0..15) at offset 1+i, command word at offset 17, status word at offset 18; offset 0 and offsets 19..31 read 0.
- R3: A command-word write taken while idle stores bits 31:1. If bit 0 is 1, the command starts and bit 0 reads 1 for at least BUSY_CYCLES cycles, then reads 0 once the command completes. Bits 31:1 keep the written value.
- R4: On completion the status word becomes bit 29 = 1, bits 7:4 = executed operation code, bits 3:0 = result code (0 ok, 1 image rejected, 2 range error, 3 unknown operation), with all other bits 0.
- R5: Operation 0x2 (block read) copies N dwords from the active bank, starting at the given address, into window dwords 0..N-1. N is the count field, except that a count of 0 means 16.
- R6: Operation 0x0 (block write) copies window dwords 0..N-1 into the inactive bank from the given address, with N = count field + 1.
- R7: A block write with the header flag (bit 1) set targets dword HDR_ADDR (default 56) and ignores the address field; the flag has no effect on other operations.
- R8: A block read or write whose start plus length exceeds DEPTH (default 64) moves no data and completes with result 2.
- R9: Operation 0x1 (update-authenticate) swaps the active and inactive banks and reports result 0 when inactive dword HDR_ADDR equals SIGNATURE (default 0x5AFEC0DE); otherwise it leaves the banks alone and reports result 1.
- R10: Operation 0x4 (power-cycle) raises restart_o for exactly one cycle at completion and reports result 0.
- R11: Any other operation code completes with result 3 and changes neither storage nor window.
- R12: While a command is pending, host writes to the command word and to the window are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 5 | Register offset for both read and write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| restart_o | output | 1 | One-cycle pulse when a power-cycle command completes |

## Verification
A wrong active-bank selector shows up as wrong data in the next block read, which can come many commands after the fault. For that reason the bench follows every authenticate with reads of the regions it wrote. A sequencer stuck busy is seen at once as a request bit that never clears. A mis-decoded length or base address shows as corrupted window dwords on the read that follows, or as a missing range error in the status word of that same command. A command latch that accepts writes while pending shows in the echoed operation code the moment the command completes.

// File: rtl/mbox_pkg.sv
package mbox_pkg;
  localparam int WIN_DW = 16;
  localparam int OFF_W  = 5;
  localparam logic [OFF_W-1:0] OFF_WIN0 = 5'd1;
  localparam logic [OFF_W-1:0] OFF_CMD  = 5'd17;
  localparam logic [OFF_W-1:0] OFF_STAT = 5'd18;

  localparam logic [3:0] OP_WRITE = 4'h0;
  localparam logic [3:0] OP_AUTH  = 4'h1;
  localparam logic [3:0] OP_READ  = 4'h2;
  localparam logic [3:0] OP_PWR   = 4'h4;

  localparam logic [3:0] RC_OK      = 4'd0;
  localparam logic [3:0] RC_REJECT  = 4'd1;
  localparam logic [3:0] RC_RANGE   = 4'd2;
  localparam logic [3:0] RC_UNKNOWN = 4'd3;

  // Number of dwords a command moves; the count field is biased differently per direction.
  function automatic logic [4:0] xfer_len(input logic [3:0] op, input logic [3:0] cnt);
    if (op == OP_READ)  return (cnt == 4'd0) ? 5'd16 : {1'b0, cnt};
    if (op == OP_WRITE) return {1'b0, cnt} + 5'd1;
    return 5'd0;
  endfunction

  // True when the span [base, base+len) lies inside a bank of the given depth.
  function automatic logic span_fits(input logic [21:0] base, input logic [4:0] len, input int depth);
    return (int'({10'd0, base}) + int'({27'd0, len})) <= depth;
  endfunction

  function automatic logic [31:0] make_status(input logic [3:0] op, input logic [3:0] code);
    logic [31:0] s;
    s       = '0;
    s[29]   = 1'b1;
    s[7:4]  = op;
    s[3:0]  = code;
    return s;
  endfunction
endpackage

// File: rtl/mbox_store.sv
module mbox_store #(
  parameter int DEPTH = 64,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rd_inact,
  input  logic [AW-1:0] rd_addr,
  output logic [31:0]   rd_data,
  input  logic          we,
  input  logic [AW-1:0] wr_addr,
  input  logic [31:0]   wr_data,
  input  logic          swap,
  output logic          act_sel
);
  logic [31:0] mem [2][DEPTH];
  logic        rd_bank;

  assign rd_bank = rd_inact ? ~act_sel : act_sel;
  assign rd_data = mem[rd_bank][rd_addr];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      act_sel <= 1'b0;
      for (int b = 0; b < 2; b++)
        for (int i = 0; i < DEPTH; i++)
          mem[b][i] <= '0;
    end else begin
      if (we)   mem[~act_sel][wr_addr] <= wr_data;
      if (swap) act_sel <= ~act_sel;
    end
  end
endmodule

// File: rtl/mbox_seq.sv
module mbox_seq
  import mbox_pkg::*;
#(
  parameter int          DEPTH       = 64,
  parameter int          BUSY_CYCLES = 4,
  parameter int          HDR_ADDR    = 56,
  parameter logic [31:0] SIGNATURE   = 32'h5AFE_C0DE,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = $clog2(BUSY_CYCLES + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [3:0]    op_in,
  input  logic [3:0]    cnt_in,
  input  logic [21:0]   addr_in,
  input  logic          hdr_in,
  output logic [3:0]    win_idx,
  output logic          win_we,
  output logic [31:0]   win_wdata,
  input  logic [31:0]   win_rdata,
  output logic          st_rd_inact,
  output logic [AW-1:0] st_rd_addr,
  input  logic [31:0]   st_rd_data,
  output logic          st_we,
  output logic [AW-1:0] st_wr_addr,
  output logic [31:0]   st_wr_data,
  output logic          pending,
  output logic          done_evt,
  output logic          swap_evt,
  output logic          restart_o,
  output logic [31:0]   status_q
);
  typedef enum logic [1:0] {S_IDLE, S_WAIT, S_XFER, S_FIN} state_e;

  state_e        state;
  logic [3:0]    op_q, cnt_q, idx_q, code_q;
  logic [21:0]   addr_q;
  logic          hdr_q, swap_q, pwr_q;
  logic [CW-1:0] busy_q;
  logic [4:0]    len_q;
  logic [AW-1:0] base_q;

  logic          wait_last, xfer_last, span_ok, img_ok;
  logic [4:0]    len_now;
  logic [21:0]   base_now;
  logic [AW-1:0] cur_addr;

  assign wait_last = (state == S_WAIT) && (busy_q == CW'(BUSY_CYCLES - 1));
  assign xfer_last = (state == S_XFER) && (({1'b0, idx_q} + 5'd1) == len_q);
  assign len_now   = xfer_len(op_q, cnt_q);
  assign base_now  = (op_q == OP_WRITE && hdr_q) ? 22'(HDR_ADDR) : addr_q;
  assign span_ok   = span_fits(base_now, len_now, DEPTH);
  assign img_ok    = (st_rd_data == SIGNATURE);
  assign cur_addr  = base_q + AW'(idx_q);

  assign st_rd_inact = (state == S_WAIT);
  assign st_rd_addr  = (state == S_XFER) ? cur_addr : AW'(HDR_ADDR);
  assign win_idx     = idx_q;
  assign win_we      = (state == S_XFER) && (op_q == OP_READ);
  assign win_wdata   = st_rd_data;
  assign st_we       = (state == S_XFER) && (op_q == OP_WRITE);
  assign st_wr_addr  = cur_addr;
  assign st_wr_data  = win_rdata;

  assign pending   = (state != S_IDLE);
  assign done_evt  = (state == S_FIN);
  assign swap_evt  = done_evt && swap_q;
  assign restart_o = done_evt && pwr_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      op_q     <= '0;
      cnt_q    <= '0;
      addr_q   <= '0;
      hdr_q    <= 1'b0;
      busy_q   <= '0;
      idx_q    <= '0;
      len_q    <= '0;
      base_q   <= '0;
      code_q   <= RC_OK;
      swap_q   <= 1'b0;
      pwr_q    <= 1'b0;
      status_q <= '0;
    end else begin
      case (state)
        S_IDLE: if (start) begin
          op_q   <= op_in;
          cnt_q  <= cnt_in;
          addr_q <= addr_in;
          hdr_q  <= hdr_in;
          busy_q <= '0;
          swap_q <= 1'b0;
          pwr_q  <= 1'b0;
          state  <= S_WAIT;
        end
        S_WAIT: begin
          if (!wait_last) begin
            busy_q <= busy_q + 1'b1;
          end else begin
            idx_q  <= '0;
            len_q  <= len_now;
            base_q <= AW'(base_now);
            code_q <= RC_OK;
            state  <= S_FIN;
            case (op_q)
              OP_READ, OP_WRITE: begin
                if (span_ok) state <= S_XFER;
                else         code_q <= RC_RANGE;
              end
              OP_AUTH: begin
                code_q <= img_ok ? RC_OK : RC_REJECT;
                swap_q <= img_ok;
              end
              OP_PWR:  pwr_q  <= 1'b1;
              default: code_q <= RC_UNKNOWN;
            endcase
          end
        end
        S_XFER: begin
          idx_q <= idx_q + 4'd1;
          if (xfer_last) state <= S_FIN;
        end
        S_FIN: begin
          status_q <= make_status(op_q, code_q);
          state    <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/mbox_cmd_engine.sv
module mbox_cmd_engine
  import mbox_pkg::*;
#(
  parameter int          DEPTH       = 64,
  parameter int          BUSY_CYCLES = 4,
  parameter int          HDR_ADDR    = 56,
  parameter logic [31:0] SIGNATURE   = 32'h5AFE_C0DE
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_wr,
  input  logic [OFF_W-1:0] bus_addr,
  input  logic [31:0]      bus_wdata,
  output logic [31:0]      bus_rdata,
  output logic             restart_o
);
  localparam int AW = $clog2(DEPTH);

  logic [31:0]   win_q [WIN_DW];
  logic [31:1]   cmd_q;
  logic [31:0]   status_q;
  logic          pending, done_evt, swap_evt, act_sel;
  logic          host_cmd_wr, accept_cmd, start, in_window, host_win_wr;
  logic [3:0]    host_slot, eng_idx;
  logic          eng_we;
  logic [31:0]   eng_wdata, eng_rdata;
  logic          st_rd_inact, st_we;
  logic [AW-1:0] st_rd_addr, st_wr_addr;
  logic [31:0]   st_rd_data, st_wr_data;

  assign in_window   = (bus_addr >= OFF_WIN0) && (bus_addr < OFF_WIN0 + OFF_W'(WIN_DW));
  assign host_slot   = 4'(bus_addr - OFF_WIN0);
  assign host_cmd_wr = bus_wr && (bus_addr == OFF_CMD);
  assign accept_cmd  = host_cmd_wr && !pending;
  assign start       = accept_cmd && bus_wdata[0];
  assign host_win_wr = bus_wr && !pending && in_window;
  assign eng_rdata   = win_q[eng_idx];

  for (genvar g = 0; g < WIN_DW; g++) begin : g_win
    always_ff @(posedge clk) begin
      if (!rst_n)                                 win_q[g] <= '0;
      else if (eng_we && eng_idx == 4'(g))        win_q[g] <= eng_wdata;
      else if (host_win_wr && host_slot == 4'(g)) win_q[g] <= bus_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)          cmd_q <= '0;
    else if (accept_cmd) cmd_q <= bus_wdata[31:1];
  end

  always_comb begin
    bus_rdata = '0;
    if (in_window)                bus_rdata = win_q[host_slot];
    else if (bus_addr == OFF_CMD)  bus_rdata = {cmd_q, pending};
    else if (bus_addr == OFF_STAT) bus_rdata = status_q;
  end

  mbox_seq #(
    .DEPTH(DEPTH), .BUSY_CYCLES(BUSY_CYCLES), .HDR_ADDR(HDR_ADDR), .SIGNATURE(SIGNATURE)
  ) seq_i (
    .clk(clk), .rst_n(rst_n), .start(start),
    .op_in(bus_wdata[31:28]), .cnt_in(bus_wdata[27:24]),
    .addr_in(bus_wdata[23:2]), .hdr_in(bus_wdata[1]),
    .win_idx(eng_idx), .win_we(eng_we), .win_wdata(eng_wdata), .win_rdata(eng_rdata),
    .st_rd_inact(st_rd_inact), .st_rd_addr(st_rd_addr), .st_rd_data(st_rd_data),
    .st_we(st_we), .st_wr_addr(st_wr_addr), .st_wr_data(st_wr_data),
    .pending(pending), .done_evt(done_evt), .swap_evt(swap_evt),
    .restart_o(restart_o), .status_q(status_q)
  );

  mbox_store #(.DEPTH(DEPTH)) store_i (
    .clk(clk), .rst_n(rst_n),
    .rd_inact(st_rd_inact), .rd_addr(st_rd_addr), .rd_data(st_rd_data),
    .we(st_we), .wr_addr(st_wr_addr), .wr_data(st_wr_data),
    .swap(swap_evt), .act_sel(act_sel)
  );
endmodule

// File: rtl/mbox_cmd_engine_chk.sv
module mbox_cmd_engine_chk #(
  parameter int BUSY_CYCLES = 4
) (
  input logic        clk,
  input logic        rst_n,
  input logic        pending,
  input logic        done_evt,
  input logic        swap_evt,
  input logic        restart_o,
  input logic        host_cmd_wr,
  input logic [31:1] cmd_q,
  input logic [31:0] status_q,
  input logic        act_sel,
  input logic        st_we
);
  logic [15:0] busy_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n || !pending)  busy_cnt <= '0;
    else if (busy_cnt != '1) busy_cnt <= busy_cnt + 16'd1;
  end

  AST_DONE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    done_evt |=> (!pending && status_q[29])); // R3
  AST_MIN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    done_evt |-> (busy_cnt >= 16'(BUSY_CYCLES))); // R3
  AST_STATUS_ECHO: assert property (@(posedge clk) disable iff (!rst_n)
    done_evt |=> (status_q[7:4] == $past(cmd_q[31:28]))); // R4
  AST_STORE_WR_ONLY_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    st_we |-> (pending && cmd_q[31:28] == 4'h0)); // R6
  AST_SWAP_ON_AUTH: assert property (@(posedge clk) disable iff (!rst_n)
    swap_evt |-> (done_evt && cmd_q[31:28] == 4'h1)); // R9
  AST_SWAP_FLIP: assert property (@(posedge clk) disable iff (!rst_n)
    swap_evt |=> (act_sel != $past(act_sel))); // R9
  AST_NO_STRAY_FLIP: assert property (@(posedge clk) disable iff (!rst_n)
    !swap_evt |=> (act_sel == $past(act_sel))); // R9
  AST_RESTART_PWR: assert property (@(posedge clk) disable iff (!rst_n)
    restart_o |-> (done_evt && cmd_q[31:28] == 4'h4)); // R10
  AST_CMD_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (pending && host_cmd_wr) |=> (cmd_q == $past(cmd_q))); // R12
endmodule

bind mbox_cmd_engine mbox_cmd_engine_chk #(.BUSY_CYCLES(BUSY_CYCLES)) chk_i (
  .clk(clk), .rst_n(rst_n), .pending(pending), .done_evt(done_evt),
  .swap_evt(swap_evt), .restart_o(restart_o), .host_cmd_wr(host_cmd_wr),
  .cmd_q(cmd_q), .status_q(status_q), .act_sel(act_sel), .st_we(st_we)
);

// File: tb/mbox_cmd_engine_tb.sv
module mbox_cmd_engine_tb_top;
  localparam int          BUSY = 6;
  localparam int          DEP  = 64;
  localparam int          HDR  = 56;
  localparam logic [31:0] SIG  = 32'h5AFE_C0DE;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [4:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        restart_o;

  int nchk = 0, nerr = 0, rcount = 0, exp_restart = 0;
  bit done = 1'b0;

  logic [31:0] m_act [DEP];
  logic [31:0] m_ina [DEP];
  logic [31:0] m_win [16];

  always #2 clk = ~clk;

  mbox_cmd_engine #(.DEPTH(DEP), .BUSY_CYCLES(BUSY), .HDR_ADDR(HDR), .SIGNATURE(SIG)) dut_i (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .restart_o(restart_o));

  always @(posedge clk) if (rst_n && restart_o) rcount++;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input int off, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = 5'(off); bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input int off, output logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b0; bus_addr = 5'(off);
    #1 d = bus_rdata;
  endtask

  function automatic logic [31:0] mk(input int op, input int cnt, input int addr, input int hdr);
    return (32'(op) << 28) | (32'(cnt & 15) << 24) | (32'(addr & 32'h3F_FFFF) << 2) | (32'(hdr & 1) << 1) | 32'd1;
  endfunction

  function automatic string tag_for(input logic [31:0] w);
    case (w[31:28])
      4'h2: return "R5";
      4'h0: return w[1] ? "R7" : "R6";
      4'h1: return "R9";
      4'h4: return "R10";
      default: return "R11";
    endcase
  endfunction

  // Reference behaviour of one command, applied to the bench's own copies.
  task automatic model(input logic [31:0] w, output logic [31:0] st);
    int op, cnt, a, base, len, code;
    logic [31:0] t;
    op = int'(w >> 28); cnt = int'((w >> 24) & 15); a = int'((w >> 2) & 32'h3F_FFFF);
    code = 0;
    if (op == 2) begin
      len = (cnt == 0) ? 16 : cnt;
      if (a + len > DEP) code = 2;
      else for (int i = 0; i < len; i++) m_win[i] = m_act[a + i];
    end else if (op == 0) begin
      len = cnt + 1;
      base = w[1] ? HDR : a;
      if (base + len > DEP) code = 2;
      else for (int i = 0; i < len; i++) m_ina[base + i] = m_win[i];
    end else if (op == 1) begin
      if (m_ina[HDR] == SIG) begin
        for (int i = 0; i < DEP; i++) begin t = m_act[i]; m_act[i] = m_ina[i]; m_ina[i] = t; end
      end else code = 1;
    end else if (op == 4) begin
      exp_restart++;
    end else code = 3;
    st = 32'h2000_0000 + 32'(op * 16 + code);
  endtask

  task automatic run_cmd(input logic [31:0] w, input string tag);
    logic [31:0] v, st, exp_st;
    int polls;
    model(w, exp_st);
    wr(17, w);
    rd(17, v);
    chk("R3 busy after request", {31'd0, v[0]}, 32'd1);
    polls = 0;
    while (v[0] && polls < 1000) begin rd(17, v); polls++; end
    chk("R3 request cleared", {31'd0, v[0]}, 32'd0);
    chk("R3 fields kept", {v[31:1], 1'b0}, {w[31:1], 1'b0});
    chk("R3 minimum busy", 32'(polls + 1 >= BUSY), 32'd1);
    rd(18, st);
    chk(tag, st, exp_st);
  endtask

  task automatic fill_win(input bit sig_first);
    logic [31:0] d;
    for (int i = 0; i < 16; i++) begin
      d = (i == 0 && sig_first) ? SIG : $urandom;
      wr(1 + i, d);
      m_win[i] = d;
    end
  endtask

  task automatic check_win(input string tag);
    logic [31:0] v;
    for (int i = 0; i < 16; i++) begin rd(1 + i, v); chk(tag, v, m_win[i]); end
  endtask

  initial begin
    logic [31:0] v, st, w;
    int sel, op;
    void'($urandom(32'd4242));
    for (int i = 0; i < DEP; i++) begin m_act[i] = '0; m_ina[i] = '0; end
    for (int i = 0; i < 16; i++) m_win[i] = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;

    // R1 / R2: reset state and offset map
    rd(17, v); chk("R1 command reset", v, 0);
    rd(18, v); chk("R1 status reset", v, 0);
    rd(1, v);  chk("R1 window reset", v, 0);
    rd(16, v); chk("R1 window last reset", v, 0);
    rd(0, v);  chk("R2 offset 0 reads zero", v, 0);
    wr(19, 32'hFFFF_FFFF); rd(19, v); chk("R2 offset 19 reads zero", v, 0);
    wr(5, 32'h1234_5678); m_win[4] = 32'h1234_5678;
    rd(5, v); chk("R2 window dword 4 at offset 5", v, 32'h1234_5678);
    run_cmd(mk(2, 0, 0, 0), "R1 active bank zero");
    check_win("R1 active bank zero");

    // R6 / R7 / R9: stage an image, authenticate, read it back
    fill_win(1'b0);
    run_cmd(mk(0, 15, 0, 0), "R6");
    fill_win(1'b1);
    run_cmd(mk(0, 0, 5, 1), "R7");
    run_cmd(mk(1, 0, 0, 0), "R9 valid image");
    run_cmd(mk(2, 0, 0, 0), "R5");
    check_win("R6 data after swap");
    run_cmd(mk(2, 1, HDR, 0), "R5");
    rd(1, v); chk("R7 header landed at fixed address", v, SIG);
    run_cmd(mk(1, 0, 0, 0), "R9 rejected image");
    run_cmd(mk(2, 3, 0, 0), "R5");
    check_win("R9 banks unchanged after reject");

    // R8: range boundaries
    run_cmd(mk(2, 0, 48, 0), "R5 block ending at last dword");
    fill_win(1'b0);
    run_cmd(mk(2, 0, 49, 0), "R8 read one past end");
    check_win("R8 window untouched");
    run_cmd(mk(0, 0, 63, 0), "R6 last dword");
    run_cmd(mk(0, 1, 63, 0), "R8 write one past end");
    run_cmd(mk(2, 1, 32'h100, 0), "R8 address far out");
    run_cmd(mk(0, 8, 0, 1), "R8 header too long");

    // R10 / R11
    run_cmd(mk(4, 0, 0, 0), "R10");
    chk("R10 restart pulse", 32'(rcount), 32'(exp_restart));
    run_cmd(mk(7, 0, 0, 0), "R11");
    check_win("R11 window untouched");

    // R12: writes while pending
    w = mk(1, 0, 0, 0);
    model(w, st);
    wr(17, w);
    wr(17, mk(2, 0, 0, 0));
    wr(1, 32'hDEAD_BEEF);
    rd(17, v);
    while (v[0]) rd(17, v);
    chk("R12 command write ignored", {v[31:1], 1'b0}, {w[31:1], 1'b0});
    rd(18, v); chk("R12 status echoes first command", v, st);
    rd(1, v);  chk("R12 window write ignored", v, m_win[0]);

    // Constrained random mix
    for (int it = 0; it < 250; it++) begin
      sel = $urandom % 8;
      case (sel)
        0, 1: begin
          fill_win(($urandom % 2) == 1);
          w = mk(0, $urandom % 16, $urandom % 72, ($urandom % 4) == 0);
          run_cmd(w, tag_for(w));
        end
        2, 3, 7: begin
          w = mk(2, $urandom % 16, $urandom % 72, 0);
          run_cmd(w, tag_for(w));
          check_win("R5 random read");
        end
        4: run_cmd(mk(1, 0, 0, 0), "R9");
        5: run_cmd(mk(4, 0, 0, 0), "R10");
        default: begin
          op = $urandom % 16;
          if (op == 0 || op == 1 || op == 2 || op == 4) op = 9;
          run_cmd(mk(op, 0, 0, 0), "R11");
        end
      endcase
    end
    chk("R10 restart count", 32'(rcount), 32'(exp_restart));

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      nchk++; nerr++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end
endmodule